// File: doc/BRIEF.md
# Flow Key Table with Tag Merge

This block keeps a small associative table of flow keys and answers commands that arrive inside tags from an upstream packet classifier. Each incoming tag carries a one-bit command and a wide digest key. A learn command places the key in the lowest-numbered free slot, unless the key is already in the table. A match command searches every slot at once. The slot number found, or the slot just written, becomes a lookup result. That result is fused with the original command and key into one merged tag, which goes to the host processor.

Both the tag input and the merged-tag output are valid/ready streams. A transfer takes place on a rising clock edge where valid and ready are both high. Once the output has raised `out_valid` it holds the tag steady until `out_ready` is seen high. When the output is stalled and the internal stage is also occupied, `in_ready` drops. `in_ready` is never low while the output holds nothing. Tags leave in the order they arrived. No tag is dropped or repeated.

The table is only ever written at the moment a command leaves the lookup stage. For this reason, each tag sees every learn that entered before it, including one from the cycle just before.

Top module: `flow_tag_table`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the table is empty, so a match issued right after reset misses.
- R2: Command encoding: `in_cmd` 1 means learn and 0 means match. The merged tag is {cmd (bit 102), hit (bit 101), overflow (bit 100), index (bits 99:96), key (bits 95:0)} with the default 16 entries and 96-bit keys.
- R3: A learn of a key that is absent, into a table with free slots, stores the key in the lowest-numbered free slot and reports hit=1, overflow=0, index=that slot.
- R4: A learn of a key already present reports hit=1 with its existing index and stores no second copy. The next new key takes the next free slot.
- R5: A learn of an absent key into a full table reports overflow=1, hit=0 and index 0, and stores nothing. A later match of that key misses. Overflow is never reported for a match.
- R6: A match of a stored key reports hit=1 and the slot index. A miss reports hit=0, overflow=0 and index 0.
- R7: The merged tag carries the incoming command and key unchanged.
- R8: With `out_ready` held high, a tag accepted on one edge appears on the output two cycles later, and one tag per cycle is sustained.
- R9: While `out_valid` is high and `out_ready` is low, the output tag stays stable. `in_ready` is high whenever the output is empty. Tags are neither lost, duplicated nor reordered under back-pressure.
- R10: A match or learn that directly follows a learn of the same key sees that key as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming tag present |
| in_ready | output | 1 | Block can accept a tag this cycle |
| in_cmd | input | 1 | Command: 1 learn, 0 match |
| in_key | input | KEY_W | Flow digest key |
| out_valid | output | 1 | Merged tag present |
| out_ready | input | 1 | Host accepts the merged tag |
| out_tag | output | 3+IDX_W+KEY_W | Merged tag {cmd, hit, overflow, index, key} |

## Verification
Every slot is filled in order by sixteen distinct learns, each timed for the two-cycle latency. This separates correct lowest-free allocation from any other slot choice. Relearns of stored keys and a seventeenth learn into the full table separate duplicate suppression from overflow handling. A full sweep of matches over all stored keys, plus keys never stored, separates hit indexing from the zero index on a miss. After a fresh reset, a learn is followed at once by a match and a relearn of the same key, exposing any write-to-lookup hazard. A pseudo-random `out_ready` pattern is then applied over mixed traffic, showing whether tags stay stable, ordered and complete under back-pressure.

// File: rtl/flow_tag_pkg.sv
package flow_tag_pkg;
  typedef enum logic {
    CMD_MATCH = 1'b0,
    CMD_LEARN = 1'b1
  } flow_cmd_e;

  localparam int FT_DEF_ENTRIES = 16;
  localparam int FT_DEF_KEY_W   = 96;
endpackage

// File: rtl/flow_lowest_one.sv
module flow_lowest_one #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/flow_key_store.sv
module flow_key_store #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 96,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [KEY_W-1:0]   look_key,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] slot_valid,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key
);
  logic [KEY_W-1:0] slot_key [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[g] <= 1'b0;
        slot_key[g]   <= '0;
      end else if (sel) begin
        slot_valid[g] <= 1'b1;
        slot_key[g]   <= wr_key;
      end
    end

    assign match_vec[g] = slot_valid[g] && (slot_key[g] == look_key);
  end
endmodule

// File: rtl/flow_tag_merge.sv
module flow_tag_merge #(
  parameter int KEY_W = 96,
  parameter int IDX_W = 4,
  localparam int TAG_W = 3 + IDX_W + KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             load_valid,
  input  logic             cmd,
  input  logic             hit,
  input  logic             ovf,
  input  logic [IDX_W-1:0] idx,
  input  logic [KEY_W-1:0] key,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tag   <= '0;
    end else if (advance) begin
      out_valid <= load_valid;
      if (load_valid) out_tag <= {cmd, hit, ovf, idx, key};
    end
  end
endmodule

// File: rtl/flow_tag_table.sv
module flow_tag_table
  import flow_tag_pkg::*;
#(
  parameter int ENTRIES = FT_DEF_ENTRIES,
  parameter int KEY_W   = FT_DEF_KEY_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int TAG_W  = 3 + IDX_W + KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_cmd,
  input  logic [KEY_W-1:0] in_key,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TAG_W-1:0] out_tag
);
  // lookup stage registers
  logic             s1_valid;
  flow_cmd_e        s1_cmd;
  logic [KEY_W-1:0] s1_key;

  logic advance, in_fire;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance || !s1_valid;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_cmd   <= CMD_MATCH;
      s1_key   <= '0;
    end else if (in_fire) begin
      s1_valid <= 1'b1;
      s1_cmd   <= flow_cmd_e'(in_cmd);
      s1_key   <= in_key;
    end else if (advance) begin
      s1_valid <= 1'b0;
    end
  end

  // table and searches
  logic [ENTRIES-1:0] match_vec, entry_valid;
  logic               hit_any, free_any, do_write;
  logic [IDX_W-1:0]   hit_idx, free_idx;

  flow_key_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .look_key(s1_key), .match_vec(match_vec),
    .slot_valid(entry_valid), .wr_en(do_write), .wr_idx(free_idx), .wr_key(s1_key)
  );

  flow_lowest_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
    .vec(match_vec), .found(hit_any), .idx(hit_idx)
  );

  flow_lowest_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
    .vec(~entry_valid), .found(free_any), .idx(free_idx)
  );

  // result formation
  logic             is_learn, res_hit, res_ovf;
  logic [IDX_W-1:0] res_idx;

  always_comb begin
    is_learn = (s1_cmd == CMD_LEARN);
    res_ovf  = is_learn && !hit_any && !free_any;
    res_hit  = hit_any || (is_learn && free_any);
    if (hit_any)                    res_idx = hit_idx;
    else if (is_learn && free_any)  res_idx = free_idx;
    else                            res_idx = '0;
    do_write = s1_valid && advance && is_learn && !hit_any && free_any;
  end

  flow_tag_merge #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .advance(advance), .load_valid(s1_valid),
    .cmd(s1_cmd), .hit(res_hit), .ovf(res_ovf), .idx(res_idx), .key(s1_key),
    .out_valid(out_valid), .out_tag(out_tag)
  );
endmodule

// File: rtl/flow_tag_table_chk.sv
module flow_tag_table_chk #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 96,
  parameter int IDX_W   = 4,
  localparam int TAG_W  = 3 + IDX_W + KEY_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [TAG_W-1:0]   out_tag,
  input logic [ENTRIES-1:0] entry_valid
);
  logic             t_cmd, t_hit, t_ovf;
  logic [IDX_W-1:0] t_idx;
  assign t_cmd = out_tag[TAG_W-1];
  assign t_hit = out_tag[TAG_W-2];
  assign t_ovf = out_tag[TAG_W-3];
  assign t_idx = out_tag[KEY_W +: IDX_W];

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tag));

  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r6_zero_idx_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !t_hit |-> t_idx == '0);

  a_r5_ovf_learn_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && t_ovf |-> t_cmd && !t_hit);

  a_r5_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && t_ovf |-> &entry_valid);

  a_r3_hit_slot_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && t_hit |-> entry_valid[t_idx]);
endmodule

bind flow_tag_table flow_tag_table_chk #(
  .ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_tag(out_tag), .entry_valid(entry_valid)
);

// File: tb/flow_tag_table_bench.sv
`timescale 1ns/1ps
module flow_tag_table_bench;
  localparam int N  = 16;
  localparam int KW = 96;
  localparam int TW = 3 + 4 + KW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_cmd = 0, out_ready = 1;
  logic [KW-1:0] in_key = '0;
  logic in_ready, out_valid;
  logic [TW-1:0] out_tag;

  flow_tag_table u_flow_tag_table (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_key(in_key), .out_valid(out_valid),
    .out_ready(out_ready), .out_tag(out_tag)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference table
  logic          m_valid [N];
  logic [KW-1:0] m_key   [N];

  // scoreboard
  logic [TW-1:0] exp_tag [512];
  int            exp_cyc [512];
  bit            exp_lat [512];
  string         exp_req [512];
  int wr = 0, rd = 0;
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] key_of(input int i);
    return {32'h1000_0000 ^ (32'(i) * 32'h9E37_79B9), 32'hC0DE_0000 + 32'(i), ~32'(i)};
  endfunction

  function automatic logic [TW-1:0] model(input logic cmd, input logic [KW-1:0] k);
    int f;
    f = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_key[i] == k) f = i;
    if (f >= 0) return {cmd, 1'b1, 1'b0, 4'(f), k};
    if (!cmd) return {cmd, 1'b0, 1'b0, 4'd0, k};
    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) f = i;
    if (f < 0) return {cmd, 1'b0, 1'b1, 4'd0, k};
    m_valid[f] = 1'b1;
    m_key[f]   = k;
    return {cmd, 1'b1, 1'b0, 4'(f), k};
  endfunction

  task automatic send(input logic cmd, input logic [KW-1:0] k, input string req);
    logic [TW-1:0] e;
    e = model(cmd, k);
    @(negedge clk);
    in_valid = 1; in_cmd = cmd; in_key = k;
    while (1) begin
      #3;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_tag[wr % 512] = e; exp_cyc[wr % 512] = cyc;
    exp_lat[wr % 512] = !stall_mode; exp_req[wr % 512] = req;
    wr++;
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic drain();
    while (rd != wr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_key[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    check(out_valid == 0, "R1", "out_valid after reset", TW'(out_valid), '0);
    check(in_ready == 1, "R1", "in_ready after reset", TW'(in_ready), TW'(1));
  endtask

  // output monitor
  logic [TW-1:0] held;
  bit have_held = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (stall_mode) begin
        out_ready = lfsr[0] | lfsr[3];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end else out_ready = 1;
      #3;
      if (rst_n) begin
        if (have_held) begin
          check(out_valid && out_tag == held, "R9", "tag held under stall", out_tag, held);
          have_held = 0;
        end
        if (out_valid) begin
          if (rd == wr) check(0, "R9", "unexpected output", out_tag, '0);
          else if (out_ready) begin
            check(out_tag == exp_tag[rd % 512], exp_req[rd % 512], "merged tag",
                  out_tag, exp_tag[rd % 512]);
            if (exp_lat[rd % 512])
              check(cyc - exp_cyc[rd % 512] == 2, "R8", "latency",
                    TW'(cyc - exp_cyc[rd % 512]), TW'(2));
            rd++;
          end else begin
            held = out_tag; have_held = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1/R6: empty table misses; R2 encoding
    send(1'b0, key_of(0), "R1/R2/R6");
    // R3/R7/R8: fill every slot in order, back to back
    for (int i = 0; i < N; i++) send(1'b1, key_of(i), "R3/R7");
    // R4: relearn returns existing slot
    send(1'b1, key_of(3), "R4");
    send(1'b1, key_of(10), "R4");
    // R5: overflow then match of the rejected key misses
    send(1'b1, key_of(40), "R5");
    send(1'b0, key_of(40), "R5");
    // R6: sweep matches over all slots and some absent keys
    for (int i = N - 1; i >= 0; i--) send(1'b0, key_of(i), "R6");
    for (int i = 100; i < 104; i++) send(1'b0, key_of(i), "R6");
    drain();
    // R10: fresh table, learn then immediate use
    do_reset();
    send(1'b1, key_of(7), "R10");
    send(1'b0, key_of(7), "R10");
    send(1'b1, key_of(7), "R10/R4");
    send(1'b1, key_of(8), "R4");
    send(1'b0, key_of(8), "R10");
    drain();
    // R9: back-pressure with mixed traffic
    stall_mode = 1;
    for (int i = 0; i < 60; i++)
      send(i[0] ^ i[2], key_of((i * 5) % 23), "R9");
    drain();
    stall_mode = 0;
    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule